// File: doc/BRIEF.md
# Serial Bus Master Frame Sequencer

This block runs one master-transmit frame on a two-wire serial bus, counted in bit slots. Before a transfer, software loads a set of values. These are its own unit address, the target's address, a 4-bit control code, a byte count and the first payload byte. The payload byte goes through the data-register write port. The frame starts on a request cycle in which the communication-enable, master-request and slave-receive-enable inputs are all high. From then on, each pulse of `slot_tick` moves the sequencer through exactly one bit slot. In each slot the block either drives a bit onto `tx_bit` with `tx_en` high, or releases the line for an acknowledge slot with `tx_en` low.

The block reports through two interrupt lines. `irq_stat` pulses in two cases: once the target has acknowledged its address, and when the frame ends for any reason. Sticky flags give the cause: done, no-acknowledge, underrun or lost arbitration. `irq_dreq` pulses for every payload byte except the last, when that byte leaves the data register. A DMA channel or software can then write the next byte.

The state machine has these states: `S_IDLE`, `S_START`, `S_BCAST`, `S_MADR`, `S_MPAR`, `S_SADR`, `S_SPAR`, `S_SACK`, `S_CTRL`, `S_CPAR`, `S_CACK`, `S_LEN`, `S_LPAR`, `S_LACK`, `S_DATA`, `S_DPAR` and `S_DACK`.
- IDLE→START happens on a full request.
- Each field state moves to its parity state once its last bit has gone out.
- Each parity state moves to the next field. For the slave address, control code, count and data, it moves to the field's acknowledge state instead.
- An acknowledge state, when acknowledged, moves on as follows:
  - SACK→CTRL.
  - CACK→LEN.
  - LACK and DACK go to DATA if bytes remain, or to IDLE if none remain.
- These events abort the frame and send the machine to IDLE:
  - a no-acknowledge;
  - an empty data register at a byte load;
  - a line mismatch in BCAST or MADR.

Top module: `serbus_master_seq`

## Requirements
- R1: After reset, `busy`, `tx_en`, `irq_stat`, `irq_dreq` and all four status flags are 0.
- R2: A frame starts only when `com_en`, `mst_req` and `rx_en` are all 1 in a cycle while `busy` is 0. If any of the three is 0, nothing starts. A request while `busy` is 1 has no effect on the frame.
- R3: The slots go out in this order:
  - a start slot driving 1;
  - the broadcast bit (`bcast`);
  - the 12-bit master address, then its parity;
  - the 12-bit slave address, then parity, then acknowledge;
  - the 4-bit control code, then parity, then acknowledge;
  - the 8-bit count, then parity, then acknowledge;
  - each data byte, then its parity, then its acknowledge.

  Every field is sent MSB first.
- R4: Each parity slot drives the XOR of the bits of the field just sent (even parity).
- R5: Acknowledge slots drive `tx_en` = 0. One follows the slave address, the control code, the count and every data byte. The master address has none. All other slots of a frame drive `tx_en` = 1. `ack_in` = 1 in an acknowledge slot means acknowledged.
- R6: `irq_stat` pulses for one cycle after the slave-address acknowledge slot is acknowledged.
- R7: The number of data bytes sent equals `tlen`. With `tlen` = 0 the frame ends after the count's acknowledge slot.
- R8: `irq_dreq` pulses once each time a data byte is taken from the data register, except for the final byte.
- R9: When the final acknowledge of a frame is accepted, `st_done` is set, `irq_stat` pulses and `busy` falls.
- R10: A no-acknowledge in any acknowledge slot ends the frame. It sets `st_nack` and pulses `irq_stat`.
- R11: If the data register is empty when a data byte is due, the frame ends. This sets `st_under` and pulses `irq_stat`.
- R12: In the broadcast and master-address slots, if `bus_in` differs from the driven bit, the frame ends. This sets `st_lost` and pulses `irq_stat`.
- R13: Status flags stay set until a `flag_clr` cycle clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_tick | input | 1 | One-cycle bit-slot strobe |
| com_en | input | 1 | Communication enable |
| mst_req | input | 1 | Master operation request |
| rx_en | input | 1 | Slave reception enable |
| flag_clr | input | 1 | Clears status flags |
| bcast | input | 1 | Broadcast bit value |
| unit_addr | input | 12 | Own (master) address |
| slave_addr | input | 12 | Target address |
| ctrl | input | 4 | Control code |
| tlen | input | 8 | Data byte count |
| dr_wr | input | 1 | Data register write strobe |
| dr_wdata | input | 8 | Data register write value |
| ack_in | input | 1 | Acknowledge sampled in acknowledge slots |
| bus_in | input | 1 | Line level read back for arbitration |
| tx_en | output | 1 | Line is driven in this slot |
| tx_bit | output | 1 | Bit driven in this slot |
| busy | output | 1 | Frame in progress |
| st_done | output | 1 | Frame completed |
| st_nack | output | 1 | Aborted on no-acknowledge |
| st_under | output | 1 | Aborted on data underrun |
| st_lost | output | 1 | Aborted on lost arbitration |
| irq_stat | output | 1 | Status interrupt pulse |
| irq_dreq | output | 1 | Data refill request pulse |

## Verification
The assertions make two assumptions about the inputs. First, `slot_tick` is never high in two consecutive cycles, so every status pulse is a single cycle. Second, the data register is never written in the same cycle that a byte is taken from it. The stimulus meets both:
- It strobes a slot every fourth cycle.
- It answers each refill request on the next cycle, well before the following byte is due.
- It preloads the first byte before the start request.

`ack_in` and `bus_in` are set half a cycle before the edge that samples them.

// File: rtl/serbus_master_seq_pkg.sv
package serbus_master_seq_pkg;
    typedef enum logic [4:0] {
        S_IDLE, S_START, S_BCAST,
        S_MADR, S_MPAR,
        S_SADR, S_SPAR, S_SACK,
        S_CTRL, S_CPAR, S_CACK,
        S_LEN,  S_LPAR, S_LACK,
        S_DATA, S_DPAR, S_DACK
    } seq_state_t;
endpackage

// File: rtl/serbus_data_reg.sv
module serbus_data_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    output logic [DW-1:0] q,
    output logic          full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            full <= 1'b0;
        end else if (wr) begin
            q    <= wdata;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R11: the sequencer never takes a byte from an empty register
    p_take_needs_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);
    // R8: a taken byte leaves the register empty until refilled
    p_take_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> !full);
endmodule

// File: rtl/serbus_status.sv
module serbus_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ev_addr,
    input  logic ev_end,
    input  logic ev_nack,
    input  logic ev_under,
    input  logic ev_lost,
    input  logic ev_dreq,
    output logic st_done,
    output logic st_nack,
    output logic st_under,
    output logic st_lost,
    output logic irq_stat,
    output logic irq_dreq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_done  <= 1'b0;
            st_nack  <= 1'b0;
            st_under <= 1'b0;
            st_lost  <= 1'b0;
            irq_stat <= 1'b0;
            irq_dreq <= 1'b0;
        end else begin
            st_done  <= (st_done  & ~clr) | ev_end;
            st_nack  <= (st_nack  & ~clr) | ev_nack;
            st_under <= (st_under & ~clr) | ev_under;
            st_lost  <= (st_lost  & ~clr) | ev_lost;
            irq_stat <= ev_addr | ev_end | ev_nack | ev_under | ev_lost;
            irq_dreq <= ev_dreq;
        end
    end

    // R13: flags hold until cleared
    p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !clr) |=> st_done);
    // R9: completion flag arrives together with a status pulse
    p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> irq_stat);
    // R6: status interrupt is a single-cycle pulse
    p_stat_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat |=> !irq_stat);
endmodule

// File: rtl/serbus_seq_fsm.sv
module serbus_seq_fsm
    import serbus_master_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 4,
    parameter int LW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_tick,
    input  logic          go,
    input  logic          bcast,
    input  logic [AW-1:0] unit_addr,
    input  logic [AW-1:0] slave_addr,
    input  logic [CW-1:0] ctrl,
    input  logic [LW-1:0] tlen,
    input  logic          ack_in,
    input  logic          bus_in,
    input  logic          dr_full,
    input  logic [DW-1:0] dr_q,
    output logic          tx_en,
    output logic          tx_bit,
    output logic          busy,
    output logic          dr_take,
    output logic          ev_addr,
    output logic          ev_end,
    output logic          ev_nack,
    output logic          ev_under,
    output logic          ev_lost,
    output logic          ev_dreq
);
    localparam int SW0  = (AW > CW) ? AW : CW;
    localparam int SW1  = (LW > DW) ? LW : DW;
    localparam int SW   = (SW0 > SW1) ? SW0 : SW1;
    localparam int CNTW = $clog2(SW + 1);

    seq_state_t      st, st_nx;
    logic [SW-1:0]   sh, sh_nx;
    logic [CNTW-1:0] cnt, cnt_nx;
    logic            par, par_nx;
    logic [LW-1:0]   left, left_nx;
    logic            in_field;

    assign busy     = (st != S_IDLE);
    assign in_field = (st == S_MADR) || (st == S_SADR) || (st == S_CTRL) ||
                      (st == S_LEN)  || (st == S_DATA);

    // slot outputs
    always_comb begin
        tx_en  = 1'b1;
        tx_bit = 1'b1;
        unique case (st)
            S_IDLE, S_SACK, S_CACK, S_LACK, S_DACK: tx_en = 1'b0;
            S_START:                                tx_bit = 1'b1;
            S_BCAST:                                tx_bit = bcast;
            S_MADR, S_SADR, S_CTRL, S_LEN, S_DATA:  tx_bit = sh[SW-1];
            S_MPAR, S_SPAR, S_CPAR, S_LPAR, S_DPAR: tx_bit = par;
            default:                                tx_en = 1'b0;
        endcase
    end

    // next state and events
    always_comb begin
        st_nx    = st;
        sh_nx    = sh;
        cnt_nx   = cnt;
        par_nx   = par;
        left_nx  = left;
        dr_take  = 1'b0;
        ev_addr  = 1'b0;
        ev_end   = 1'b0;
        ev_nack  = 1'b0;
        ev_under = 1'b0;
        ev_lost  = 1'b0;
        ev_dreq  = 1'b0;
        if (st == S_IDLE) begin
            if (go) st_nx = S_START;
        end else if (slot_tick) begin
            if (in_field) begin
                par_nx = par ^ sh[SW-1];
                sh_nx  = sh << 1;
                cnt_nx = cnt - 1'b1;
            end
            unique case (st)
                S_START: st_nx = S_BCAST;
                S_BCAST: begin
                    if (bus_in != tx_bit) begin
                        st_nx   = S_IDLE;
                        ev_lost = 1'b1;
                    end else begin
                        st_nx  = S_MADR;
                        sh_nx  = SW'(unit_addr) << (SW - AW);
                        cnt_nx = CNTW'(AW - 1);
                        par_nx = 1'b0;
                    end
                end
                S_MADR: begin
                    if (bus_in != tx_bit) begin
                        st_nx   = S_IDLE;
                        ev_lost = 1'b1;
                    end else if (cnt == '0) begin
                        st_nx = S_MPAR;
                    end
                end
                S_MPAR: begin
                    st_nx  = S_SADR;
                    sh_nx  = SW'(slave_addr) << (SW - AW);
                    cnt_nx = CNTW'(AW - 1);
                    par_nx = 1'b0;
                end
                S_SADR: if (cnt == '0) st_nx = S_SPAR;
                S_SPAR: st_nx = S_SACK;
                S_SACK: begin
                    if (!ack_in) begin
                        st_nx   = S_IDLE;
                        ev_nack = 1'b1;
                    end else begin
                        st_nx   = S_CTRL;
                        ev_addr = 1'b1;
                        sh_nx   = SW'(ctrl) << (SW - CW);
                        cnt_nx  = CNTW'(CW - 1);
                        par_nx  = 1'b0;
                    end
                end
                S_CTRL: if (cnt == '0) st_nx = S_CPAR;
                S_CPAR: st_nx = S_CACK;
                S_CACK: begin
                    if (!ack_in) begin
                        st_nx   = S_IDLE;
                        ev_nack = 1'b1;
                    end else begin
                        st_nx   = S_LEN;
                        sh_nx   = SW'(tlen) << (SW - LW);
                        cnt_nx  = CNTW'(LW - 1);
                        par_nx  = 1'b0;
                        left_nx = tlen;
                    end
                end
                S_LEN:  if (cnt == '0) st_nx = S_LPAR;
                S_LPAR: st_nx = S_LACK;
                S_DATA: if (cnt == '0) st_nx = S_DPAR;
                S_DPAR: st_nx = S_DACK;
                S_LACK, S_DACK: begin
                    if (!ack_in) begin
                        st_nx   = S_IDLE;
                        ev_nack = 1'b1;
                    end else if (left == '0) begin
                        st_nx  = S_IDLE;
                        ev_end = 1'b1;
                    end else if (!dr_full) begin
                        st_nx    = S_IDLE;
                        ev_under = 1'b1;
                    end else begin
                        st_nx   = S_DATA;
                        sh_nx   = SW'(dr_q) << (SW - DW);
                        cnt_nx  = CNTW'(DW - 1);
                        par_nx  = 1'b0;
                        left_nx = left - 1'b1;
                        dr_take = 1'b1;
                        ev_dreq = (left != LW'(1));
                    end
                end
                default: st_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            sh   <= '0;
            cnt  <= '0;
            par  <= 1'b0;
            left <= '0;
        end else begin
            st   <= st_nx;
            sh   <= sh_nx;
            cnt  <= cnt_nx;
            par  <= par_nx;
            left <= left_nx;
        end
    end

    // R2: a full request in idle starts the frame on the next edge
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && go) |=> (st == S_START));
    // R3: outside idle the sequencer advances only on a slot strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE && !slot_tick) |=> $stable(st));
    // R5: an acknowledge state is always entered from its parity slot
    p_ack_after_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == S_SACK) |-> $past(st) == S_SPAR);
endmodule

// File: rtl/serbus_master_seq.sv
module serbus_master_seq
    import serbus_master_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 4,
    parameter int LW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_tick,
    input  logic          com_en,
    input  logic          mst_req,
    input  logic          rx_en,
    input  logic          flag_clr,
    input  logic          bcast,
    input  logic [AW-1:0] unit_addr,
    input  logic [AW-1:0] slave_addr,
    input  logic [CW-1:0] ctrl,
    input  logic [LW-1:0] tlen,
    input  logic          dr_wr,
    input  logic [DW-1:0] dr_wdata,
    input  logic          ack_in,
    input  logic          bus_in,
    output logic          tx_en,
    output logic          tx_bit,
    output logic          busy,
    output logic          st_done,
    output logic          st_nack,
    output logic          st_under,
    output logic          st_lost,
    output logic          irq_stat,
    output logic          irq_dreq
);
    logic          go;
    logic          dr_full, dr_take;
    logic [DW-1:0] dr_q;
    logic          ev_addr, ev_end, ev_nack, ev_under, ev_lost, ev_dreq;

    assign go = com_en & mst_req & rx_en;

    serbus_data_reg #(.DW(DW)) u_dreg (
        .clk(clk), .rst_n(rst_n), .wr(dr_wr), .wdata(dr_wdata),
        .take(dr_take), .q(dr_q), .full(dr_full)
    );

    serbus_seq_fsm #(.AW(AW), .CW(CW), .LW(LW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .go(go),
        .bcast(bcast), .unit_addr(unit_addr), .slave_addr(slave_addr),
        .ctrl(ctrl), .tlen(tlen), .ack_in(ack_in), .bus_in(bus_in),
        .dr_full(dr_full), .dr_q(dr_q), .tx_en(tx_en), .tx_bit(tx_bit),
        .busy(busy), .dr_take(dr_take), .ev_addr(ev_addr), .ev_end(ev_end),
        .ev_nack(ev_nack), .ev_under(ev_under), .ev_lost(ev_lost),
        .ev_dreq(ev_dreq)
    );

    serbus_status u_stat (
        .clk(clk), .rst_n(rst_n), .clr(flag_clr), .ev_addr(ev_addr),
        .ev_end(ev_end), .ev_nack(ev_nack), .ev_under(ev_under),
        .ev_lost(ev_lost), .ev_dreq(ev_dreq), .st_done(st_done),
        .st_nack(st_nack), .st_under(st_under), .st_lost(st_lost),
        .irq_stat(irq_stat), .irq_dreq(irq_dreq)
    );

    // R8: refill requests only occur while a frame is running
    p_dreq_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dreq |-> busy);
    // R9: line is released whenever no frame runs
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_en);
endmodule

// File: tb/serbus_master_seq_test.sv
module serbus_master_seq_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        slot_tick = 0, com_en = 0, mst_req = 0, rx_en = 0, flag_clr = 0;
    logic        bcast = 0, dr_wr = 0, ack_in = 1, bus_in = 1;
    logic [11:0] unit_addr = 0, slave_addr = 0;
    logic [3:0]  ctrl = 0;
    logic [7:0]  tlen = 0, dr_wdata = 0;
    logic        tx_en, tx_bit, busy, st_done, st_nack, st_under, st_lost;
    logic        irq_stat, irq_dreq;

    serbus_master_seq uut (.*);

    typedef struct { logic en; logic b; string tag; } slot_t;
    slot_t exq[$];
    int n_chk = 0, n_fail = 0;
    int ack_idx, nack_at, slot_idx, lose_at, under_at, fill_idx;
    int n_stat, n_dreq;
    bit fill_req = 0;
    logic [7:0] fill_data;
    logic [7:0] dat [16];
    // expected-model state
    bit e_stop, e_addr;
    int e_kind, e_slots, e_acks, e_dreq;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected slots, answers acknowledge and arbitration
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_stat) n_stat++;
            if (irq_dreq) begin
                n_dreq++;
                fill_idx++;
                if (fill_idx != under_at) begin
                    fill_req  = 1;
                    fill_data = dat[fill_idx];
                end
            end
            if (slot_tick && busy) begin
                if (exq.size() == 0) begin
                    chk(0, "R3", "unexpected extra slot", slot_idx, -1);
                end else begin
                    slot_t e;
                    e = exq.pop_front();
                    chk(tx_en == e.en, e.tag, "slot drive enable", tx_en, e.en);
                    if (e.en) chk(tx_bit == e.b, e.tag, "slot bit", tx_bit, e.b);
                end
                if (!tx_en) begin
                    ack_in = (ack_idx != nack_at);
                    ack_idx++;
                end
                bus_in = (slot_idx == lose_at) ? ~tx_bit : tx_bit;
                slot_idx++;
            end
        end
    end

    task automatic put(logic en, logic b, string tag);
        if (e_stop) return;
        exq.push_back('{en, b, tag});
        e_slots++;
        if (e_slots - 1 == lose_at) begin e_stop = 1; e_kind = 3; end
    endtask

    task automatic put_field(int v, int w);
        logic p = 0;
        for (int i = w - 1; i >= 0; i--) begin
            put(1'b1, v[i], "R3");
            p ^= v[i];
        end
        put(1'b1, p, "R4");
    endtask

    task automatic put_ack();
        if (e_stop) return;
        put(1'b0, 1'b1, "R5");
        if (e_acks == nack_at) begin e_stop = 1; e_kind = 1; end
        else if (e_acks == 0) e_addr = 1;
        e_acks++;
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic run_frame(int ua, int sa, int ct, int len, bit bc,
                             int nack, int lose, int under, bit poke);
        bit started = 0;
        nack_at = nack; lose_at = lose; under_at = under;
        ack_idx = 0; slot_idx = 0; fill_idx = 0; n_stat = 0; n_dreq = 0;
        ack_in = 1; bus_in = 1;
        for (int i = 0; i < 16; i++) dat[i] = 8'((ua * 7) + (i * 37) + sa);
        // expected stream
        exq.delete();
        e_stop = 0; e_addr = 0; e_kind = 0; e_slots = 0; e_acks = 0; e_dreq = 0;
        put(1'b1, 1'b1, "R3");
        put(1'b1, bc, "R3");
        put_field(ua, 12);
        put_field(sa, 12); put_ack();
        put_field(ct, 4);  put_ack();
        put_field(len, 8); put_ack();
        for (int i = 0; i < len; i++) begin
            if (!e_stop && i == under) begin e_stop = 1; e_kind = 2; end
            if (!e_stop && i != len - 1) e_dreq++;
            put_field(dat[i], 8); put_ack();
        end
        // drive configuration and preload
        unit_addr = 12'(ua); slave_addr = 12'(sa); ctrl = 4'(ct);
        tlen = 8'(len); bcast = bc;
        cyc();
        if (len > 0 && under != 0) begin dr_wr = 1; dr_wdata = dat[0]; end
        cyc();
        dr_wr = 0; com_en = 1; mst_req = 1; rx_en = 1;
        for (int c = 0; c < 6000; c++) begin
            cyc();
            com_en  = poke && (c == 61);
            mst_req = poke && (c == 61);
            rx_en   = poke && (c == 61);
            slot_tick = (c % 4 == 3);
            dr_wr = 0;
            if (fill_req) begin dr_wr = 1; dr_wdata = fill_data; fill_req = 0; end
            if (busy) started = 1;
            if (started && !busy) break;
        end
        slot_tick = 0; dr_wr = 0; com_en = 0; mst_req = 0; rx_en = 0;
        cyc(); cyc(); cyc();
        chk(!busy, "R9", "busy after frame", busy, 0);
        chk(exq.size() == 0, poke ? "R2" : "R7", "slots left unsent", exq.size(), 0);
        chk(st_done  == (e_kind == 0), "R9",  "done flag",     st_done,  e_kind == 0);
        chk(st_nack  == (e_kind == 1), "R10", "nack flag",     st_nack,  e_kind == 1);
        chk(st_under == (e_kind == 2), "R11", "underrun flag", st_under, e_kind == 2);
        chk(st_lost  == (e_kind == 3), "R12", "lost flag",     st_lost,  e_kind == 3);
        chk(n_stat == 32'(e_addr) + 1, "R6", "status pulses", n_stat, 32'(e_addr) + 1);
        chk(n_dreq == e_dreq, "R8", "refill pulses", n_dreq, e_dreq);
        // R13: flags held, then cleared
        repeat (5) cyc();
        chk((st_done | st_nack | st_under | st_lost) == 1'b1, "R13", "flag held", 0, 1);
        flag_clr = 1; cyc(); flag_clr = 0; cyc();
        chk({st_done, st_nack, st_under, st_lost} == 4'b0, "R13", "flags cleared",
            {st_done, st_nack, st_under, st_lost}, 0);
    endtask

    bit finished = 0;
    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        chk({busy, tx_en, irq_stat, irq_dreq, st_done, st_nack, st_under, st_lost} == 8'b0,
            "R1", "reset outputs",
            {busy, tx_en, irq_stat, irq_dreq, st_done, st_nack, st_under, st_lost}, 0);
        rst_n = 1;
        cyc();
        // R2: incomplete request does not start
        com_en = 1; mst_req = 1; rx_en = 0;
        cyc(); com_en = 0; mst_req = 0;
        for (int c = 0; c < 12; c++) begin slot_tick = (c % 4 == 3); cyc(); end
        slot_tick = 0;
        chk(!busy && !tx_en, "R2", "start without slave-receive enable", busy, 0);
        run_frame(12'h5A3, 12'h1C7, 4'hB, 3, 1, -1, -1, -1, 1); // R2 poke, R3..R9
        run_frame(12'h0F0, 12'h3E1, 4'h6, 0, 0, -1, -1, -1, 0); // R7 zero length
        run_frame(12'hA5C, 12'h777, 4'h1, 1, 1, -1, -1, -1, 0); // R8 single byte
        run_frame(12'h123, 12'h456, 4'h9, 2, 0, -1, -1, 0, 0);  // R11 first byte
        run_frame(12'hFED, 12'h0B4, 4'h3, 4, 1, -1, -1, 2, 0);  // R11 third byte
        run_frame(12'h321, 12'h654, 4'h2, 2, 0, 0, -1, -1, 0);  // R10 slave ack
        run_frame(12'h9C9, 12'h2A2, 4'hE, 3, 1, 4, -1, -1, 0);  // R10 data ack
        run_frame(12'h800, 12'h111, 4'h5, 2, 1, -1, 1, -1, 0);  // R12 broadcast
        run_frame(12'h7FF, 12'h222, 4'h5, 2, 0, -1, 7, -1, 0);  // R12 address
        run_frame(12'h0AB, 12'hCDE, 4'hF, 5, 0, -1, -1, -1, 0); // R3 R4 long
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule